// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a per-core countdown timer that advances on a free-running bus-clock strobe (nominally one strobe every 10 ns, a 100 MHz timer clock). A prescaler divides that strobe by a power of two chosen in a divide-configuration register, and each divided tick decrements a current-count value. Software starts the timer by writing an initial count. The count readable at any moment is therefore the initial count less the divided ticks seen since that write.

When the count steps from one to zero, the timer raises a one-cycle interrupt request that carries the 8-bit vector held in its control entry, unless that entry is masked. In one-shot mode the count then rests at zero. In periodic mode it reloads the initial count on the following divided tick. The interrupt request is only signalled here. Routing and delivering it are left to a neighbouring block. Software reaches the registers through a small synchronous port: a write lands on the clock edge, and a read returns data one cycle after `rd_en`.

Top module: `local_timer`

## Requirements
- R1: The divide register (address 3) stores only bits 3, 1 and 0 of a write. Every other bit reads back as zero, so a read returns the written value ANDed with 0xB.
- R2: The divider code is {bit3, bit1, bit0} of the divide register. The divide ratio is 2 to the power ((code+1) mod 8), so code 7 (value 0xB) divides by 1, code 0 by 2, code 3 (value 0x3) by 16 and code 6 (value 0xA) by 128.
- R3: A write to the initial-count register (address 1) loads the current count and restarts the prescaler from zero. The current count (address 2, read-only) then equals the initial count minus the divided ticks elapsed since that write.
- R4: The control entry (address 0) keeps vector bits 7:0, bit 12, mask bit 16 and periodic bit 17. Other written bits read as zero. After reset the entry reads 0x00010000, which means masked.
- R5: On the divided tick that moves the count from 1 to 0, `irq_req` is high for exactly the next cycle, and `irq_vec` then carries the control entry's vector.
- R6: While mask bit 16 is set, expiry raises no `irq_req`, and the count still decrements to zero.
- R7: In one-shot mode (bit 17 clear) the count stays at zero after expiry.
- R8: In periodic mode the count reloads the initial count on the divided tick after it reaches zero. Successive requests are therefore (initial+1) divided ticks apart.
- R9: An initial count of zero stops the timer. The current count reads zero and no request is raised.
- R10: A divide-register write leaves the current count unchanged. The new ratio applies only after the prescaler next wraps. A load of the initial count adopts the divide setting in force at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bus-clock strobe, one cycle per base timer period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data valid next cycle |
| addr | input | 2 | Register select: 0 control, 1 initial count, 2 current count, 3 divide |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_req | output | 1 | One-cycle interrupt request on unmasked expiry |
| irq_vec | output | 8 | Vector that accompanies `irq_req` |

## Verification
The bench builds the timer with a 16-bit count (CNT_W = 16). At that width, random initial counts of a few dozen, combined with every divider code up to divide-by-128, expire and reload many times within a short run. Directed sequences measure the cycles from load to request for divide ratios 1, 2, 16 and 128. They also measure the periodic spacing and follow a ratio change made between prescaler wraps. The random phase mixes divide, control and count writes with strobes that arrive on only some cycles. This exercises a load colliding with a tick, a mask change near expiry, and a reload from zero.

// File: rtl/local_timer.sv
module local_timer #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_req,
  output logic [7:0]  irq_vec
);
  localparam int PRE_W = 7;
  localparam logic [1:0] A_CTL = 2'd0, A_INIT = 2'd1, A_CUR = 2'd2, A_DIV = 2'd3;
  localparam logic [17:0] CTL_KEEP = 18'h310FF;
  localparam logic [17:0] CTL_RST  = 18'h10000;

  logic [17:0]      ctl_q;
  logic [CNT_W-1:0] init_q, cur_q;
  logic [3:0]       div_q;
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       shift_q;

  logic [2:0]       cfg_shift;
  logic [7:0]       ratio;
  logic [PRE_W-1:0] pre_lim;
  logic             wrap, load, expire;
  logic [31:0]      rd_mux;

  assign cfg_shift = 3'({div_q[3], div_q[1:0]} + 3'd1);
  assign ratio     = 8'd1 << shift_q;
  assign pre_lim   = PRE_W'(ratio - 8'd1);
  assign wrap      = tick && (pre_q >= pre_lim);
  assign load      = wr_en && (addr == A_INIT);
  assign expire    = wrap && (cur_q == CNT_W'(1));

  always_comb begin
    case (addr)
      A_CTL:   rd_mux = 32'(ctl_q);
      A_INIT:  rd_mux = 32'(init_q);
      A_CUR:   rd_mux = 32'(cur_q);
      default: rd_mux = 32'(div_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RST;
      init_q  <= '0;
      cur_q   <= '0;
      div_q   <= '0;
      pre_q   <= '0;
      shift_q <= 3'd1;
      irq_req <= 1'b0;
      irq_vec <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTL:   ctl_q  <= wdata[17:0] & CTL_KEEP;
          A_INIT:  init_q <= wdata[CNT_W-1:0];
          A_DIV:   div_q  <= wdata[3:0] & 4'hB;
          default: ;
        endcase
      end

      if (load) begin
        pre_q   <= '0;
        shift_q <= cfg_shift;
      end else if (tick) begin
        pre_q <= wrap ? '0 : PRE_W'(pre_q + 1'b1);
        if (wrap) shift_q <= cfg_shift;
      end

      if (load)
        cur_q <= wdata[CNT_W-1:0];
      else if (wrap) begin
        if (cur_q != '0)
          cur_q <= cur_q - 1'b1;
        else if (ctl_q[17] && init_q != '0)
          cur_q <= init_q;
      end

      irq_req <= expire && !ctl_q[16];
      if (expire) irq_vec <= ctl_q[7:0];

      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/local_timer_chk.sv
module local_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [31:0]      rdata,
  input logic             irq_req,
  input logic [17:0]      ctl_q,
  input logic [CNT_W-1:0] init_q,
  input logic [CNT_W-1:0] cur_q
);
  logic ld;
  assign ld = wr_en && (addr == 2'd1);

  // R1
  div_rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> ((rdata & ~32'hB) == 32'd0));

  // R4
  ctl_rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=> ((rdata & ~32'h310FF) == 32'd0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cur_q != '0) |=> (cur_q == $past(cur_q) || cur_q == $past(cur_q) - 1'b1));

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(cur_q) == CNT_W'(1)));

  // R6
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(ctl_q[16]));

  // R7
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == '0 && !ctl_q[17] && !ld) |=> (cur_q == '0));

  // R9
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0 && cur_q == '0 && !ld) |=> (cur_q == '0));

  // R10
  div_write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !tick) |=> (cur_q == $past(cur_q)));
endmodule

bind local_timer local_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .rdata(rdata), .irq_req(irq_req), .ctl_q(ctl_q),
  .init_q(init_q), .cur_q(cur_q)
);

// File: tb/local_timer_tb.sv
module local_timer_tb;
  localparam int CNT_W = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  local_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  logic [17:0]      m_ctl;
  logic [CNT_W-1:0] m_init, m_cur;
  logic [3:0]       m_div;
  int               m_pre;
  int               m_shift;
  logic             m_irq;
  logic [7:0]       m_vec;
  logic [31:0]      m_rdata;

  function automatic int shift_of(logic [3:0] d);
    return ({d[3], d[1], d[0]} + 1) % 8;
  endfunction

  function automatic int ratio_of(logic [3:0] d);
    return 1 << shift_of(d);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl = 18'h10000; m_init = '0; m_cur = '0; m_div = '0;
    m_pre = 0; m_shift = 1; m_irq = 1'b0; m_vec = '0; m_rdata = '0;
  endtask

  task automatic model_step(bit t, bit we, bit re, logic [1:0] a, logic [31:0] wd);
    bit ld, wr;
    logic [31:0] rm;
    ld = we && a == 2'd1;
    wr = t && (m_pre >= (1 << m_shift) - 1);
    case (a)
      2'd0: rm = 32'(m_ctl);
      2'd1: rm = 32'(m_init);
      2'd2: rm = 32'(m_cur);
      default: rm = 32'(m_div);
    endcase
    m_irq = wr && m_cur == 1 && !m_ctl[16];
    if (wr && m_cur == 1) m_vec = m_ctl[7:0];
    if (ld) begin m_pre = 0; m_shift = shift_of(m_div); end
    else if (t) begin
      m_pre = wr ? 0 : m_pre + 1;
      if (wr) m_shift = shift_of(m_div);
    end
    if (ld) m_cur = wd[CNT_W-1:0];
    else if (wr) begin
      if (m_cur != 0) m_cur = m_cur - 1'b1;
      else if (m_ctl[17] && m_init != 0) m_cur = m_init;
    end
    if (we) case (a)
      2'd0: m_ctl = wd[17:0] & 18'h310FF;
      2'd1: m_init = wd[CNT_W-1:0];
      2'd3: m_div = wd[3:0] & 4'hB;
      default: ;
    endcase
    if (re) m_rdata = rm;
  endtask

  function automatic string tag_of(logic [1:0] a);
    case (a)
      2'd0: return "R4 control readback";
      2'd1: return "R3 initial readback";
      2'd2: return "R3 current count";
      default: return "R1 divide readback";
    endcase
  endfunction

  task automatic step(bit t, bit we, bit re, logic [1:0] a, logic [31:0] wd);
    tick = t; wr_en = we; rd_en = re; addr = a; wdata = wd;
    @(posedge clk);
    model_step(t, we, re, a, wd);
    @(negedge clk);
    chk("R5 irq_req", 32'(irq_req), 32'(m_irq));
    if (m_irq) chk("R5 irq_vec", 32'(irq_vec), 32'(m_vec));
    if (re) chk(tag_of(a), rdata, m_rdata);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    step(1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    step(1'b0, 1'b0, 1'b1, a, '0);
    d = rdata;
  endtask

  task automatic ticks_to_irq(output int n);
    n = 0;
    do begin
      step(1'b1, 1'b0, 1'b0, 2'd0, '0);
      n++;
    end while (!irq_req && n < 2000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    int seen;
    logic [3:0] codes [4];
    codes[0] = 4'hB; codes[1] = 4'h0; codes[2] = 4'h3; codes[3] = 4'hA;

    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state: R4 masked entry, R9 zero counts
    rd(2'd0, d); chk("R4 reset control", d, 32'h10000);
    rd(2'd2, d); chk("R9 reset count", d, 32'd0);
    rd(2'd3, d); chk("R1 reset divide", d, 32'd0);

    // R1 write mask
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R1 divide mask", d, 32'hB);

    // R4 control mask
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R4 control mask", d, 32'h310FF);
    wr(2'd0, 32'h0000_0042);

    // R2 ratio per code, R5 vector
    foreach (codes[i]) begin
      wr(2'd3, 32'(codes[i]));
      wr(2'd1, 32'd3);
      ticks_to_irq(n);
      chk("R2 ticks to expiry", 32'(n), 32'(3 * ratio_of(codes[i])));
      chk("R5 vector", 32'(irq_vec), 32'h42);
    end

    // R7 one-shot rests at zero
    repeat (20) step(1'b1, 1'b0, 1'b0, 2'd0, '0);
    rd(2'd2, d); chk("R7 one-shot hold", d, 32'd0);

    // R3 elapsed ticks
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd10);
    repeat (4) step(1'b1, 1'b0, 1'b0, 2'd0, '0);
    rd(2'd2, d); chk("R3 count after 4 ticks", d, 32'd6);

    // R8 periodic spacing
    wr(2'd0, 32'h2_0055);
    wr(2'd1, 32'd2);
    ticks_to_irq(n);
    ticks_to_irq(n);
    chk("R8 periodic spacing", 32'(n), 32'd3);
    chk("R8 vector", 32'(irq_vec), 32'h55);

    // R6 masked expiry still counts
    wr(2'd0, 32'h1_0066);
    wr(2'd1, 32'd2);
    seen = 0;
    repeat (4) begin
      step(1'b1, 1'b0, 1'b0, 2'd0, '0);
      if (irq_req) seen++;
    end
    chk("R6 masked no request", 32'(seen), 32'd0);
    rd(2'd2, d); chk("R6 masked count reached zero", d, 32'd0);

    // R9 zero initial count stops
    wr(2'd0, 32'h2_0077);
    wr(2'd1, 32'd0);
    seen = 0;
    repeat (8) begin
      step(1'b1, 1'b0, 1'b0, 2'd0, '0);
      if (irq_req) seen++;
    end
    rd(2'd2, d); chk("R9 stopped count", d, 32'd0);
    chk("R9 no request", 32'(seen), 32'd0);

    // R10 ratio change waits for wrap
    wr(2'd0, 32'h0000_0011);
    wr(2'd3, 32'h0);
    wr(2'd1, 32'd4);
    step(1'b1, 1'b0, 1'b0, 2'd0, '0);
    wr(2'd3, 32'h1);
    rd(2'd2, d); chk("R10 count unchanged", d, 32'd4);
    ticks_to_irq(n);
    chk("R10 ticks after change", 32'(n), 32'd13);

    // constrained random
    void'($urandom(32'h1A2B3C));
    for (int k = 0; k < 6000; k++) begin
      int r;
      bit t, we, re;
      logic [1:0] a;
      logic [31:0] wd;
      r  = $urandom_range(0, 99);
      t  = $urandom_range(0, 99) < 60;
      we = r < 8;
      re = !we && r < 40;
      a  = 2'($urandom_range(0, 3));
      wd = $urandom();
      if (we && a == 2'd1) wd = (r < 1) ? 32'd0 : 32'($urandom_range(1, 40));
      if (we && a == 2'd2) a = 2'd3;
      step(t, we, re, a, wd);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule